// File: doc/BRIEF.md
# Same-ID Ordering Hazard Tracker

This block keeps a dependency matrix for a request queue of `DEPTH` slots. Every queued slot has a transaction ID and a direction, read or write. A new request can only be allowed to start after every older queued request with the same ID and the same direction has left the queue. When a request is allocated into a slot, the block compares it with every live slot. It then marks a dependency bit in the new slot's row for each older slot that matches. When a slot retires, its column is wiped from every row. A slot reports ready once it is live and its row holds no bits.

The block checks two kinds of hazard only: a read behind a read, and a write behind a write. A read and a write that share an ID never wait on each other. One slot can wait on any number of older slots at the same time. The scheduler that picks among ready slots is outside this block, and so is the storage of the request payloads.

Top module: `hzd_tracker`

## Requirements
- R1: After reset every slot is empty, and the whole `ready` vector is 0.
- R2: A request allocated into a slot with no matching live request makes that slot's `ready` bit 1 in the cycle after the allocation edge.
- R3: A read (`alloc_wr`=0) allocated while a live read with the same `alloc_id` is queued is not ready after allocation.
- R4: A write (`alloc_wr`=1) allocated while a live write with the same ID is queued is not ready after allocation.
- R5: A read and a write never depend on each other, even when their IDs are equal.
- R6: Requests with different IDs never depend on each other.
- R7: A slot can depend on several older slots at once. It becomes ready only after all of them have retired. A slot never depends on itself.
- R8: Retiring a slot clears its dependency bit in every other slot. A slot whose last dependency retires becomes ready in the cycle after that retire edge.
- R9: If a request is allocated in the same cycle that a matching slot retires, no dependency on the retiring slot is recorded.
- R10: A retired slot reads 0 on `ready` from the cycle after the retire edge until it is allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_en | input | 1 | Allocate a request this cycle |
| alloc_slot | input | $clog2(DEPTH) | Slot receiving the new request |
| alloc_id | input | ID_W | Transaction ID of the new request |
| alloc_wr | input | 1 | Direction of the new request: 1 = write, 0 = read |
| retire_en | input | 1 | Retire a slot this cycle |
| retire_slot | input | $clog2(DEPTH) | Slot being retired |
| ready | output | DEPTH | Per-slot flag: slot is live and has no outstanding dependency |

## Verification
The assertions assume a well-behaved queue manager, which the block itself does not enforce:
- an allocation always targets an empty slot;
- a slot is never allocated and retired in the same cycle;
- a retire never targets the slot allocated one cycle later.

Under those conditions, a hazard found at allocation must keep the slot not ready on the next cycle, and a clean allocation must make it ready.

The bench drives its stimulus from a reference model of live slots. It allocates only into slots that the model holds empty, and it retires only live slots that differ from the allocation target. Its same-cycle cases always pair an allocation with the retirement of a different slot.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } dir_e;

  function automatic dir_e dir_of(input logic wr_bit);
    return wr_bit ? DIR_WR : DIR_RD;
  endfunction

endpackage

// File: rtl/hzd_slot_table.sv
module hzd_slot_table #(
  parameter  int DEPTH  = 8,
  parameter  int ID_W   = 4,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    alloc_en,
  input  logic [SLOT_W-1:0]       alloc_slot,
  input  logic [ID_W-1:0]         alloc_id,
  input  hzd_pkg::dir_e           alloc_dir,
  input  logic                    retire_en,
  input  logic [SLOT_W-1:0]       retire_slot,
  output logic [DEPTH-1:0]        ent_valid,
  output logic [DEPTH*ID_W-1:0]   ent_id,
  output logic [DEPTH-1:0]        ent_wr
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic          take;
    logic          drop;
    logic [ID_W-1:0] id_q;
    hzd_pkg::dir_e dir_q;

    assign take = alloc_en  && (alloc_slot  == SLOT_W'(s));
    assign drop = retire_en && (retire_slot == SLOT_W'(s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_valid[s] <= 1'b0;
        id_q         <= '0;
        dir_q        <= hzd_pkg::DIR_RD;
      end else if (take) begin
        ent_valid[s] <= 1'b1;
        id_q         <= alloc_id;
        dir_q        <= alloc_dir;
      end else if (drop) begin
        ent_valid[s] <= 1'b0;
      end
    end

    assign ent_id[s*ID_W +: ID_W] = id_q;
    assign ent_wr[s]              = (dir_q == hzd_pkg::DIR_WR);
  end

endmodule

// File: rtl/hzd_compare.sv
module hzd_compare #(
  parameter  int DEPTH  = 8,
  parameter  int ID_W   = 4,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]      ent_valid,
  input  logic [DEPTH*ID_W-1:0] ent_id,
  input  logic [DEPTH-1:0]      ent_wr,
  input  logic [ID_W-1:0]       new_id,
  input  logic                  new_wr,
  input  logic [SLOT_W-1:0]     new_slot,
  input  logic                  retire_en,
  input  logic [SLOT_W-1:0]     retire_slot,
  output logic [DEPTH-1:0]      dep_new,
  output logic                  hz_hit
);

  // Same ID and same direction is a hazard; a read/write pair never is.
  function automatic logic same_stream(input logic [ID_W-1:0] a_id, input logic a_wr,
                                       input logic [ID_W-1:0] b_id, input logic b_wr);
    return (a_id == b_id) && (a_wr == b_wr);
  endfunction

  for (genvar j = 0; j < DEPTH; j++) begin : g_cmp
    logic leaving;
    logic self;
    assign leaving    = retire_en && (retire_slot == SLOT_W'(j));
    assign self       = (new_slot == SLOT_W'(j));
    assign dep_new[j] = ent_valid[j] && !leaving && !self &&
                        same_stream(ent_id[j*ID_W +: ID_W], ent_wr[j], new_id, new_wr);
  end

  assign hz_hit = |dep_new;

endmodule

// File: rtl/hzd_dep_row.sv
module hzd_dep_row #(
  parameter  int DEPTH  = 8,
  parameter  int ROW    = 0,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DEPTH-1:0]  load_vec,
  input  logic              clr_en,
  input  logic [SLOT_W-1:0] clr_slot,
  output logic [DEPTH-1:0]  row_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0;
    end else if (load) begin
      row_q <= load_vec;
    end else if (clr_en) begin
      if (clr_slot == SLOT_W'(ROW)) row_q <= '0;
      else                          row_q[clr_slot] <= 1'b0;
    end
  end

endmodule

// File: rtl/hzd_tracker.sv
module hzd_tracker #(
  parameter  int DEPTH  = 8,
  parameter  int ID_W   = 4,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [SLOT_W-1:0] alloc_slot,
  input  logic [ID_W-1:0]   alloc_id,
  input  logic              alloc_wr,
  input  logic              retire_en,
  input  logic [SLOT_W-1:0] retire_slot,
  output logic [DEPTH-1:0]  ready
);

  logic [DEPTH-1:0]       entry_valid;
  logic [DEPTH*ID_W-1:0]  entry_id;
  logic [DEPTH-1:0]       entry_wr;
  logic [DEPTH-1:0]       dep_new;
  logic                   hz_hit;
  logic [DEPTH*DEPTH-1:0] dep_flat;
  logic [DEPTH-1:0]       busy;

  hzd_slot_table #(.DEPTH(DEPTH), .ID_W(ID_W)) i_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_en    (alloc_en),
    .alloc_slot  (alloc_slot),
    .alloc_id    (alloc_id),
    .alloc_dir   (hzd_pkg::dir_of(alloc_wr)),
    .retire_en   (retire_en),
    .retire_slot (retire_slot),
    .ent_valid   (entry_valid),
    .ent_id      (entry_id),
    .ent_wr      (entry_wr)
  );

  hzd_compare #(.DEPTH(DEPTH), .ID_W(ID_W)) i_cmp (
    .ent_valid   (entry_valid),
    .ent_id      (entry_id),
    .ent_wr      (entry_wr),
    .new_id      (alloc_id),
    .new_wr      (alloc_wr),
    .new_slot    (alloc_slot),
    .retire_en   (retire_en),
    .retire_slot (retire_slot),
    .dep_new     (dep_new),
    .hz_hit      (hz_hit)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic             load_row;
    logic [DEPTH-1:0] row_bits;
    assign load_row = alloc_en && (alloc_slot == SLOT_W'(i));

    hzd_dep_row #(.DEPTH(DEPTH), .ROW(i)) i_row (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_row),
      .load_vec (dep_new),
      .clr_en   (retire_en),
      .clr_slot (retire_slot),
      .row_q    (row_bits)
    );

    assign dep_flat[i*DEPTH +: DEPTH] = row_bits;
    assign busy[i]                    = |row_bits;
  end

  assign ready = entry_valid & ~busy;

endmodule

// File: rtl/hzd_tracker_chk.sv
module hzd_tracker_chk #(
  parameter  int DEPTH  = 8,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   alloc_en,
  input logic [SLOT_W-1:0]      alloc_slot,
  input logic                   retire_en,
  input logic [SLOT_W-1:0]      retire_slot,
  input logic [DEPTH-1:0]       ready,
  input logic [DEPTH-1:0]       entry_valid,
  input logic [DEPTH*DEPTH-1:0] dep_flat,
  input logic                   hz_hit
);

  logic [DEPTH-1:0] col_any;

  always_comb begin
    col_any = '0;
    for (int r = 0; r < DEPTH; r++)
      for (int c = 0; c < DEPTH; c++)
        if (dep_flat[r*DEPTH + c]) col_any[c] = 1'b1;
  end

  AST_HAZARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && hz_hit) |=> !ready[$past(alloc_slot)]);  // R3

  AST_CLEAN_ALLOC_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !hz_hit && !(retire_en && retire_slot == alloc_slot))
    |=> ready[$past(alloc_slot)]);  // R2

  AST_RETIRED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_en && !(alloc_en && alloc_slot == retire_slot))
    |=> !ready[$past(retire_slot)]);  // R10

  for (genvar k = 0; k < DEPTH; k++) begin : g_chk
    AST_COLUMN_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_en && retire_slot == SLOT_W'(k) && !(alloc_en && alloc_slot == SLOT_W'(k)))
      |=> !col_any[k]);  // R8

    AST_NO_SELF_DEP: assert property (@(posedge clk) disable iff (!rst_n)
      !dep_flat[k*DEPTH + k]);  // R7

    AST_READY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ready[k] |-> entry_valid[k]);  // R10
  end

endmodule

bind hzd_tracker hzd_tracker_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_en    (alloc_en),
  .alloc_slot  (alloc_slot),
  .retire_en   (retire_en),
  .retire_slot (retire_slot),
  .ready       (ready),
  .entry_valid (entry_valid),
  .dep_flat    (dep_flat),
  .hz_hit      (hz_hit)
);

// File: tb/test_hzd_tracker.sv
module test_hzd_tracker;

  localparam int DEPTH  = 8;
  localparam int ID_W   = 4;
  localparam int SLOT_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              alloc_en;
  logic [SLOT_W-1:0] alloc_slot;
  logic [ID_W-1:0]   alloc_id;
  logic              alloc_wr;
  logic              retire_en;
  logic [SLOT_W-1:0] retire_slot;
  logic [DEPTH-1:0]  ready;

  always #10 clk = ~clk;  // 50 MHz

  hzd_tracker #(.DEPTH(DEPTH), .ID_W(ID_W)) i_hzd_tracker (
    .clk, .rst_n, .alloc_en, .alloc_slot, .alloc_id, .alloc_wr,
    .retire_en, .retire_slot, .ready
  );

  typedef struct {
    logic [DEPTH-1:0] exp;
    string            req;
  } item_t;

  item_t exp_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  bit    done   = 0;

  // Reference state built from the requirements
  bit              m_valid [DEPTH];
  bit [ID_W-1:0]   m_id    [DEPTH];
  bit              m_wr    [DEPTH];
  bit [DEPTH-1:0]  m_dep   [DEPTH];

  function automatic logic [DEPTH-1:0] model_ready();
    logic [DEPTH-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i] = m_valid[i] && (m_dep[i] == '0);
    return v;
  endfunction

  task automatic push_exp(input string req);
    item_t it;
    it.exp = model_ready();
    it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic op(input bit a_en, input int a_slot, input int a_id, input bit a_wr,
                    input bit r_en, input int r_slot, input string req);
    bit [DEPTH-1:0] nd;
    @(negedge clk);
    alloc_en    = a_en;
    alloc_slot  = SLOT_W'(a_slot);
    alloc_id    = ID_W'(a_id);
    alloc_wr    = a_wr;
    retire_en   = r_en;
    retire_slot = SLOT_W'(r_slot);
    nd = '0;
    for (int j = 0; j < DEPTH; j++)
      if (m_valid[j] && j != a_slot && !(r_en && j == r_slot) &&
          m_id[j] == ID_W'(a_id) && m_wr[j] == a_wr) nd[j] = 1'b1;
    @(posedge clk);
    #1;
    alloc_en  = 1'b0;
    retire_en = 1'b0;
    if (r_en) begin
      for (int i = 0; i < DEPTH; i++) m_dep[i][r_slot] = 1'b0;
      m_dep[r_slot]   = '0;
      m_valid[r_slot] = 1'b0;
    end
    if (a_en) begin
      m_valid[a_slot] = 1'b1;
      m_id[a_slot]    = ID_W'(a_id);
      m_wr[a_slot]    = a_wr;
      m_dep[a_slot]   = nd;
    end
    push_exp(req);
  endtask

  // Monitor: compares one expected vector at each falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (ready !== it.exp) begin
          n_fail++;
          $display("FAIL %s: ready actual=%b expected=%b", it.req, ready, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    alloc_en = 0; alloc_slot = '0; alloc_id = '0; alloc_wr = 0;
    retire_en = 0; retire_slot = '0;
    for (int i = 0; i < DEPTH; i++) begin
      m_valid[i] = 0; m_id[i] = '0; m_wr[i] = 0; m_dep[i] = '0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    push_exp("R1 reset empty");

    op(1, 0, 3, 0, 0, 0, "R2 clean read");
    op(1, 1, 3, 0, 0, 0, "R3 read behind read");
    op(1, 2, 3, 1, 0, 0, "R5 write vs read same id");
    op(1, 3, 3, 1, 0, 0, "R4 write behind write");
    op(1, 4, 5, 0, 0, 0, "R6 other id");
    op(1, 5, 3, 0, 0, 0, "R7 two dependencies");
    op(0, 0, 0, 0, 1, 0, "R8 retire slot0, R10 slot0 idle");
    op(0, 0, 0, 0, 1, 1, "R7 last dependency gone");
    op(0, 0, 0, 0, 1, 2, "R8 write chain released");
    op(1, 6, 3, 1, 1, 3, "R9 alloc with matching retire");
    op(1, 7, 5, 0, 1, 6, "R3 read behind other-id read");
    op(0, 0, 0, 0, 1, 4, "R8 retire slot4");
    op(0, 0, 0, 0, 1, 5, "R10 retire slot5");
    op(0, 0, 0, 0, 1, 7, "R1 queue empty again");

    // Full-depth write chain with one ID, then drain in order
    for (int s = 0; s < DEPTH; s++) op(1, s, 9, 1, 0, 0, "R4 chain alloc");
    for (int s = 0; s < DEPTH; s++) op(0, 0, 0, 0, 1, s, "R8 chain drain");

    // Interleaved read/write with equal IDs across every slot
    for (int s = 0; s < DEPTH; s++) op(1, s, 2, s % 2, 0, 0, "R5 mixed chain");
    for (int s = DEPTH - 1; s >= 0; s--) op(0, 0, 0, 0, 1, s, "R7 reverse drain");

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule